// File: doc/BRIEF.md
# Inter-Processor Mailbox Register Bank

This block holds the small set of registers two processors use to pass words and signal each other. It is seen from the secondary processor's side. The secondary side gets one load/store port that does 32-bit or 16-bit accesses. A separate primary-side port loads the primary's mailbox and raises bits in two flag registers. Every register is also brought out as a plain output, so the primary side can see it at all times.

The registers have different write rules. The primary mailbox is read-only to the secondary. The secondary mailbox is a plain storage word. One flag register clears the bits written as 1 (write-one-to-clear). Another sets the bits written as 1 (write-one-to-set). A control register toggles a nibble of handshake bits, and its read data has fixed bits forced high. A pending register always reads as zero, and any write to it empties it.

The caller decodes the mailbox page and passes in two pieces of the byte address: address bit 11 as `sec_addr_hi` and address bits [7:4] as `sec_addr_sel`. Read data is combinational from the current register state. Writes take effect at the next rising clock edge.

Top module: `mbx_bank`

## Requirements
- R1: An active-low asynchronous reset clears all six registers to zero. After reset a word read of select 4 returns 0xF0000002 and every other select reads zero.
- R2: Select 0 reads the primary mailbox. Secondary writes of either width to select 0 leave it unchanged. A primary-side load (`prim_mbox_we`) replaces it at the next edge.
- R3: A secondary word write to select 1 replaces all 32 bits of the secondary mailbox. A 16-bit write replaces bits [15:0] and keeps bits [31:16]. The value appears on `prim_sec_mbox`.
- R4: A secondary word write to select 2 clears every bit of the done register that is 1 in the write data. `prim_done_set` ORs bits into that register every cycle. When both act in the same cycle, the primary set is applied first and the secondary clear second.
- R5: A secondary word write to select 3 ORs the write data into the post register.
- R6: On a write of either width to select 4, the control register is updated in two steps. First, if data bit 5 or bit 7 is 1, bits [15:12] become 0b0010. Second, with t = data[7:4] placed at bits [7:4], the bits of t are cleared if the register (after the first step) has any of them set; otherwise they are set.
- R7: A word read of select 4 returns the control value ORed with 0xF0000002. A 16-bit read returns its low half ORed with 0x0002.
- R8: Reads of select 6 return zero at both widths. A secondary write of either width to select 6 clears the pending register at the next edge. `prim_pend_set` ORs bits into the pending register, and a same-cycle secondary write still leaves it zero.
- R9: A word access with `sec_addr_hi`=1, or with a select other than 0, 1, 2, 3, 4 or 6, reads zero and changes no register. A 16-bit access ignores `sec_addr_hi`.
- R10: A 16-bit read returns bits [15:0] of the selected register, zero-extended. A 16-bit write to select 0, 2 or 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_we | input | 1 | Secondary write strobe for this cycle |
| sec_half | input | 1 | 1 = 16-bit access, 0 = 32-bit access |
| sec_addr_hi | input | 1 | Byte address bit 11 |
| sec_addr_sel | input | 4 | Byte address bits [7:4], register select |
| sec_wdata | input | 32 | Secondary write data (16-bit writes use [15:0]) |
| sec_rdata | output | 32 | Secondary read data for the current address |
| prim_mbox_we | input | 1 | Primary load strobe for the primary mailbox |
| prim_mbox_wdata | input | 32 | Primary mailbox load value |
| prim_done_set | input | 32 | Bits to set in the done register this cycle |
| prim_pend_set | input | 32 | Bits to set in the pending register this cycle |
| prim_sec_mbox | output | 32 | Secondary mailbox contents |
| prim_done_bits | output | 32 | Done register contents |
| prim_post_bits | output | 32 | Post register contents |
| prim_ctl | output | 32 | Control register contents, without the forced bits |
| prim_pend | output | 32 | Pending register contents |

## Verification
The assertions check the rules that hold on every cycle:
- The primary mailbox holds unless it is loaded.
- Clear, set and full-word writes have the expected effect one edge later.
- A pending write always empties that register.
- The forced control bits are always present on a word read.
- Pending and out-of-map word reads return zero.

The toggle arithmetic of the control register, the ordering of a primary set against a same-cycle secondary clear, and the halfword write and read rules can only be shown by the bench's scenarios. The bench compares every select at both widths against an arithmetic model after each random access.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int MBX_DW   = 32;
    localparam int MBX_HW   = MBX_DW / 2;
    localparam int MBX_SELW = 4;

    // Register select codes, equal to byte address bits [7:4]
    localparam logic [MBX_SELW-1:0] CODE_PRI  = 4'h0;
    localparam logic [MBX_SELW-1:0] CODE_SEC  = 4'h1;
    localparam logic [MBX_SELW-1:0] CODE_DONE = 4'h2;
    localparam logic [MBX_SELW-1:0] CODE_POST = 4'h3;
    localparam logic [MBX_SELW-1:0] CODE_CTL  = 4'h4;
    localparam logic [MBX_SELW-1:0] CODE_PEND = 4'h6;

    typedef enum logic [2:0] {
        SEL_PRI,
        SEL_SEC,
        SEL_DONE,
        SEL_POST,
        SEL_CTL,
        SEL_PEND,
        SEL_NONE
    } sel_e;

    typedef struct packed {
        logic [MBX_DW-1:0] pri;
        logic [MBX_DW-1:0] sec;
        logic [MBX_DW-1:0] done;
        logic [MBX_DW-1:0] post;
        logic [MBX_DW-1:0] ctl;
        logic [MBX_DW-1:0] pend;
    } regs_t;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
(
    input  logic                addr_hi,
    input  logic [MBX_SELW-1:0] addr_sel,
    input  logic                half,
    output sel_e                sel
);
    logic word_blocked;

    // Word accesses decode bit 11 as well; halfword accesses ignore it
    assign word_blocked = !half && addr_hi;

    always_comb begin
        sel = SEL_NONE;
        if (!word_blocked) begin
            unique case (addr_sel)
                CODE_PRI:  sel = SEL_PRI;
                CODE_SEC:  sel = SEL_SEC;
                CODE_DONE: sel = SEL_DONE;
                CODE_POST: sel = SEL_POST;
                CODE_CTL:  sel = SEL_CTL;
                CODE_PEND: sel = SEL_PEND;
                default:   sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/mbx_ctl_next.sv
module mbx_ctl_next
    import mbx_pkg::*;
(
    input  logic [MBX_DW-1:0] cur,
    input  logic [3:0]        hs_bits,
    output logic [MBX_DW-1:0] nxt
);
    logic [MBX_DW-1:0] stage_d;
    logic [MBX_DW-1:0] tog_mask;
    logic              rearm;

    // hs_bits carries write data [7:4]; bits 5 and 7 re-arm the state nibble
    assign rearm    = hs_bits[1] | hs_bits[3];
    assign tog_mask = {{(MBX_DW-8){1'b0}}, hs_bits, 4'b0000};

    always_comb begin
        stage_d = cur;
        if (rearm) begin
            stage_d[15:12] = 4'b0010;
        end
        if ((stage_d & tog_mask) != '0) begin
            nxt = stage_d & ~tog_mask;
        end else begin
            nxt = stage_d | tog_mask;
        end
    end
endmodule

// File: rtl/mbx_rdmux.sv
module mbx_rdmux
    import mbx_pkg::*;
#(
    parameter logic [MBX_DW-1:0] CTL_WORD_OR = 32'hF000_0002,
    parameter logic [MBX_HW-1:0] CTL_HALF_OR = 16'h0002
)(
    input  regs_t             regs,
    input  sel_e              sel,
    input  logic              half,
    output logic [MBX_DW-1:0] rdata
);
    logic [MBX_DW-1:0] word_v;
    logic [MBX_HW-1:0] half_v;

    always_comb begin
        unique case (sel)
            SEL_PRI:  word_v = regs.pri;
            SEL_SEC:  word_v = regs.sec;
            SEL_DONE: word_v = regs.done;
            SEL_POST: word_v = regs.post;
            SEL_CTL:  word_v = regs.ctl | CTL_WORD_OR;
            default:  word_v = '0;
        endcase
        half_v = word_v[MBX_HW-1:0];
        if (sel == SEL_CTL) begin
            half_v = regs.ctl[MBX_HW-1:0] | CTL_HALF_OR;
        end
        rdata = half ? {{MBX_HW{1'b0}}, half_v} : word_v;
    end
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
    import mbx_pkg::*;
#(
    parameter logic [MBX_DW-1:0] CTL_WORD_OR = 32'hF000_0002,
    parameter logic [MBX_HW-1:0] CTL_HALF_OR = 16'h0002
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sec_we,
    input  logic                sec_half,
    input  logic                sec_addr_hi,
    input  logic [MBX_SELW-1:0] sec_addr_sel,
    input  logic [MBX_DW-1:0]   sec_wdata,
    output logic [MBX_DW-1:0]   sec_rdata,
    input  logic                prim_mbox_we,
    input  logic [MBX_DW-1:0]   prim_mbox_wdata,
    input  logic [MBX_DW-1:0]   prim_done_set,
    input  logic [MBX_DW-1:0]   prim_pend_set,
    output logic [MBX_DW-1:0]   prim_sec_mbox,
    output logic [MBX_DW-1:0]   prim_done_bits,
    output logic [MBX_DW-1:0]   prim_post_bits,
    output logic [MBX_DW-1:0]   prim_ctl,
    output logic [MBX_DW-1:0]   prim_pend
);
    regs_t             regs_d, regs_q;
    sel_e              sel;
    logic [MBX_DW-1:0] ctl_toggled;

    mbx_decode u_decode (
        .addr_hi  (sec_addr_hi),
        .addr_sel (sec_addr_sel),
        .half     (sec_half),
        .sel      (sel)
    );

    mbx_ctl_next u_ctl (
        .cur     (regs_q.ctl),
        .hs_bits (sec_wdata[7:4]),
        .nxt     (ctl_toggled)
    );

    mbx_rdmux #(
        .CTL_WORD_OR (CTL_WORD_OR),
        .CTL_HALF_OR (CTL_HALF_OR)
    ) u_rdmux (
        .regs  (regs_q),
        .sel   (sel),
        .half  (sec_half),
        .rdata (sec_rdata)
    );

    // Next state: primary-side updates first, secondary write merged after
    always_comb begin
        regs_d      = regs_q;
        if (prim_mbox_we) begin
            regs_d.pri = prim_mbox_wdata;
        end
        regs_d.done = regs_d.done | prim_done_set;
        regs_d.pend = regs_d.pend | prim_pend_set;
        if (sec_we) begin
            unique case (sel)
                SEL_SEC: begin
                    if (sec_half) begin
                        regs_d.sec[MBX_HW-1:0] = sec_wdata[MBX_HW-1:0];
                    end else begin
                        regs_d.sec = sec_wdata;
                    end
                end
                SEL_DONE: begin
                    if (!sec_half) begin
                        regs_d.done = regs_d.done & ~sec_wdata;
                    end
                end
                SEL_POST: begin
                    if (!sec_half) begin
                        regs_d.post = regs_d.post | sec_wdata;
                    end
                end
                SEL_CTL:  regs_d.ctl  = ctl_toggled;
                SEL_PEND: regs_d.pend = '0;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign prim_sec_mbox  = regs_q.sec;
    assign prim_done_bits = regs_q.done;
    assign prim_post_bits = regs_q.post;
    assign prim_ctl       = regs_q.ctl;
    assign prim_pend      = regs_q.pend;

    // R2: primary mailbox only moves on a primary load
    assert_pri_mbox_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !prim_mbox_we |=> regs_q.pri == $past(regs_q.pri));

    // R3: full-word write to the secondary mailbox
    assert_sec_mbox_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_we && !sec_half && sel == SEL_SEC) |=> prim_sec_mbox == $past(sec_wdata));

    // R4: bits written as one are clear afterwards
    assert_done_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_we && !sec_half && sel == SEL_DONE) |=> (prim_done_bits & $past(sec_wdata)) == '0);

    // R5: bits written as one are set afterwards
    assert_post_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_we && !sec_half && sel == SEL_POST)
        |=> (prim_post_bits & $past(sec_wdata)) == $past(sec_wdata));

    // R7: forced bits always present on a word read of the control register
    assert_ctl_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_half && sel == SEL_CTL) |-> (sec_rdata[31:28] == 4'hF && sec_rdata[1]));

    // R8: pending register reads zero and is emptied by any write
    assert_pend_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_PEND) |-> sec_rdata == '0);
    assert_pend_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_we && sel == SEL_PEND) |=> prim_pend == '0);

    // R9: word access with address bit 11 set reads zero
    assert_word_hi_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_half && sec_addr_hi) |-> sec_rdata == '0);
endmodule

// File: tb/mbx_bank_tb_top.sv
module mbx_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_we = 1'b0, sec_half = 1'b0, sec_addr_hi = 1'b0;
    logic [3:0]  sec_addr_sel = 4'h0;
    logic [31:0] sec_wdata = '0, sec_rdata;
    logic        prim_mbox_we = 1'b0;
    logic [31:0] prim_mbox_wdata = '0, prim_done_set = '0, prim_pend_set = '0;
    logic [31:0] prim_sec_mbox, prim_done_bits, prim_post_bits, prim_ctl, prim_pend;

    int total = 0;
    int bad   = 0;
    logic [31:0] m_pri = '0, m_sec = '0, m_done = '0, m_post = '0, m_ctl = '0, m_pend = '0;
    logic [31:0] rng = 32'h1234_5678;

    always #10 clk = ~clk;

    mbx_bank dut_i (
        .clk(clk), .rst_n(rst_n),
        .sec_we(sec_we), .sec_half(sec_half), .sec_addr_hi(sec_addr_hi),
        .sec_addr_sel(sec_addr_sel), .sec_wdata(sec_wdata), .sec_rdata(sec_rdata),
        .prim_mbox_we(prim_mbox_we), .prim_mbox_wdata(prim_mbox_wdata),
        .prim_done_set(prim_done_set), .prim_pend_set(prim_pend_set),
        .prim_sec_mbox(prim_sec_mbox), .prim_done_bits(prim_done_bits),
        .prim_post_bits(prim_post_bits), .prim_ctl(prim_ctl), .prim_pend(prim_pend)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] v = s;
        v = v ^ (v << 13);
        v = v ^ (v >> 17);
        v = v ^ (v << 5);
        return v;
    endfunction

    // Control rule from R6, in arithmetic form
    function automatic logic [31:0] ctl_rule(input logic [31:0] c, input logic [31:0] w);
        logic [31:0] r = c;
        logic [31:0] t = w & 32'h0000_00F0;
        if ((w & 32'h0000_00A0) != 0) r = (r & 32'hFFFF_0FFF) | 32'h0000_2000;
        if ((r & t) != 0) return r & ~t;
        return r | t;
    endfunction

    function automatic logic [31:0] exp_rd(input logic hi, input logic [3:0] sel, input logic h);
        logic [31:0] v;
        if (!h && hi) return 32'h0;
        case (sel)
            4'h0: v = m_pri;
            4'h1: v = m_sec;
            4'h2: v = m_done;
            4'h3: v = m_post;
            4'h4: v = m_ctl | 32'hF000_0002;
            default: v = 32'h0;
        endcase
        if (h) v = v & 32'h0000_FFFF;
        return v;
    endfunction

    function automatic string tag_of(input logic hi, input logic [3:0] sel, input logic h);
        if (!h && hi) return "R9";
        case (sel)
            4'h0: return h ? "R10" : "R2";
            4'h1: return "R3";
            4'h2: return h ? "R10" : "R4";
            4'h3: return h ? "R10" : "R5";
            4'h4: return "R7";
            4'h6: return "R8";
            default: return "R9";
        endcase
    endfunction

    // One clocked access on both ports; the model follows R2..R10
    task automatic access(input logic pwe, input logic [31:0] pdat, input logic [31:0] pdone,
                          input logic [31:0] ppend, input logic swe, input logic sh,
                          input logic shi, input logic [3:0] ssel, input logic [31:0] sdat);
        @(negedge clk);
        prim_mbox_we = pwe; prim_mbox_wdata = pdat; prim_done_set = pdone; prim_pend_set = ppend;
        sec_we = swe; sec_half = sh; sec_addr_hi = shi; sec_addr_sel = ssel; sec_wdata = sdat;
        @(posedge clk);
        #1;
        if (pwe) m_pri = pdat;
        m_done = m_done | pdone;
        m_pend = m_pend | ppend;
        if (swe && !(!sh && shi)) begin
            case (ssel)
                4'h1: m_sec = sh ? {m_sec[31:16], sdat[15:0]} : sdat;
                4'h2: if (!sh) m_done = m_done & ~sdat;
                4'h3: if (!sh) m_post = m_post | sdat;
                4'h4: m_ctl = ctl_rule(m_ctl, sdat);
                4'h6: m_pend = 32'h0;
                default: ;
            endcase
        end
        prim_mbox_we = 1'b0; prim_done_set = '0; prim_pend_set = '0; sec_we = 1'b0;
    endtask

    task automatic read_one(input logic hi, input logic [3:0] sel, input logic h, output logic [31:0] v);
        sec_we = 1'b0; sec_addr_hi = hi; sec_addr_sel = sel; sec_half = h;
        #1;
        v = sec_rdata;
    endtask

    task automatic sweep_reads(input string pfx);
        logic [31:0] v;
        for (int s = 0; s < 16; s++) begin
            for (int hi = 0; hi < 2; hi++) begin
                for (int h = 0; h < 2; h++) begin
                    read_one(hi[0], s[3:0], h[0], v);
                    chk({pfx, tag_of(hi[0], s[3:0], h[0])}, v, exp_rd(hi[0], s[3:0], h[0]));
                end
            end
        end
        chk({pfx, "R3 view"}, prim_sec_mbox, m_sec);
        chk({pfx, "R4 view"}, prim_done_bits, m_done);
        chk({pfx, "R5 view"}, prim_post_bits, m_post);
        chk({pfx, "R6 view"}, prim_ctl, m_ctl);
        chk({pfx, "R8 view"}, prim_pend, m_pend);
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state, ctl reads only the forced bits
        read_one(1'b0, 4'h4, 1'b0, v);
        chk("R1 ctl after reset", v, 32'hF000_0002);
        sweep_reads("R1 reset/");
        @(negedge clk);
        rst_n = 1'b1;

        // R6: directed toggle sequence with literal expectations
        access(0, 0, 0, 0, 1, 0, 0, 4'h4, 32'h0000_0020);
        chk("R6 rearm+set", prim_ctl, 32'h0000_2020);
        access(0, 0, 0, 0, 1, 1, 0, 4'h4, 32'h0000_0020);
        chk("R6 toggle clear (half)", prim_ctl, 32'h0000_2000);
        access(0, 0, 0, 0, 1, 0, 0, 4'h4, 32'h0000_0010);
        chk("R6 set bit4", prim_ctl, 32'h0000_2010);
        access(0, 0, 0, 0, 1, 0, 0, 4'h4, 32'h0000_0030);
        chk("R6 shared clear", prim_ctl, 32'h0000_2000);
        read_one(1'b1, 4'h4, 1'b1, v);
        chk("R7 half read bit11 ignored", v, 32'h0000_2002);

        // R4: primary set merged before secondary clear
        access(0, 0, 32'hFFFF_0000, 0, 1, 0, 0, 4'h2, 32'h0F0F_0000);
        chk("R4 merge order", prim_done_bits, 32'hF0F0_0000);
        // R8: pending set and clear in the same cycle ends empty
        access(0, 0, 0, 32'h0000_00FF, 1, 1, 0, 4'h6, 32'h0);
        chk("R8 same-cycle clear", prim_pend, 32'h0);
        // R10: halfword writes to 0, 2, 3 change nothing
        access(1, 32'hCAFE_0001, 0, 0, 0, 0, 0, 4'h0, 0);
        access(0, 0, 0, 0, 1, 1, 0, 4'h0, 32'h0000_5555);
        access(0, 0, 0, 0, 1, 1, 0, 4'h2, 32'hFFFF_FFFF);
        access(0, 0, 0, 0, 1, 1, 0, 4'h3, 32'hFFFF_FFFF);
        chk("R10 pri untouched", m_pri, 32'hCAFE_0001);
        chk("R10 done untouched", prim_done_bits, 32'hF0F0_0000);
        chk("R10 post untouched", prim_post_bits, 32'h0);
        // R2: secondary word write to the primary mailbox is ignored
        access(0, 0, 0, 0, 1, 0, 0, 4'h0, 32'h1111_1111);
        read_one(1'b0, 4'h0, 1'b0, v);
        chk("R2 write ignored", v, 32'hCAFE_0001);
        // R9: word write with bit 11 set changes nothing
        access(0, 0, 0, 0, 1, 0, 1, 4'h1, 32'hDEAD_BEEF);
        chk("R9 hi word write ignored", prim_sec_mbox, 32'h0);
        sweep_reads("directed/");

        // Random sweep over both ports, every select and both widths
        for (int it = 0; it < 400; it++) begin
            logic [31:0] a, b, c;
            rng = next_rng(rng); a = rng;
            rng = next_rng(rng); b = rng;
            rng = next_rng(rng); c = rng;
            access(a[0], b, a[1] ? (c & b) : 32'h0, a[2] ? (b ^ c) : 32'h0,
                   a[3] | a[4], a[5], a[6] & a[7], {1'b0, a[10:8]} | (a[11] ? 4'h8 : 4'h0), c);
            sweep_reads("sweep/");
        end
        finish_run();
    end
endmodule